// File: doc/BRIEF.md
# Dual-Channel Phase Delay Aligner

Two modulator streams are clocked in lockstep, each producing one small signed code per sample, and each feeds its own decimation filter. This block sits between the streams and the filters. A programmable phase value sets a fixed delay, counted in modulator samples, that is applied to exactly one of the two streams before decimation. The two filter outputs then carry a constant and known phase offset instead of converting the same instant.

The phase value is an 8-bit two's-complement number. A positive value holds back channel 0, a negative value holds back channel 1, and the other channel passes with the same one-cycle register latency as the delayed path's zero tap. The magnitude is clamped to one less than the oversampling ratio. Writing the phase value flushes the sample history of both channels to the zero code and raises a one-cycle resync pulse so the filters restart their settling. The block also produces a frame strobe, shared by both channels, that marks every OSR-th sample counted from the last write or reset. Downstream filters dump their words on this strobe, so both channels decimate on the same sample.

Top module: `pda_phase_aligner`

## Requirements
- R1: After reset both output codes are 0, out_valid, out_frame and out_resync are low, and the applied delay is zero on both channels.
- R2: With a phase value p between 1 and 127 (8-bit two's complement), the channel 0 output for the n-th valid sample after the last write equals channel 0 input sample n-min(p,OSR-1), and channel 1 output equals channel 1 input sample n.
- R3: With a negative phase value p, channel 1 is delayed by min(-p,OSR-1) samples and channel 0 passes undelayed. A phase value of 0 delays neither channel.
- R4: Delay magnitudes above OSR-1 are clamped to OSR-1, including the value -128 (8'h80).
- R5: A phase write empties both histories. Until d samples have arrived after the write, the delayed channel outputs the zero code 4'b0000. out_resync is high for exactly the one cycle after the write cycle.
- R6: Every valid input sample produces one output sample with out_valid high exactly one clock later. Output codes hold their value in cycles without a valid input.
- R7: out_frame is high together with out_valid for the valid samples whose index since the last write or reset is OSR-1, 2*OSR-1, and so on. It is shared by both channels.
- R8: When a phase write and a valid sample fall in the same cycle, that sample is index 0 of the new history, and it is delayed according to the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe common to both channels |
| in_code0 | input | CODE_W | Channel 0 modulator code |
| in_code1 | input | CODE_W | Channel 1 modulator code |
| phase_wr | input | 1 | Write strobe for the phase value |
| phase_wdata | input | 8 | Phase value, two's complement |
| out_valid | output | 1 | Output sample strobe |
| out_code0 | output | CODE_W | Aligned channel 0 code |
| out_code1 | output | CODE_W | Aligned channel 1 code |
| out_frame | output | 1 | Shared decimation frame strobe |
| out_resync | output | 1 | One-cycle pulse after a phase write |

## Verification
A phase write and a valid sample can arrive in the same cycle. In that cycle the history flush, the new delay selection and the frame counter restart all meet the incoming sample. The bench provokes this on purpose, writing a new phase both in a valid cycle and in an idle cycle while the stream keeps running. A queue-based model restarts its history at the write and counts that sample as index 0. On every clock the model is compared with the delayed codes, the zero fill, the resync pulse and the frame strobe. Both channels are given identical streams, so any misalignment shows up directly as a sample offset different from the programmed one.

// File: rtl/pda_pkg.sv
package pda_pkg;

    localparam int PHASE_W = 8;
    localparam int MAG_W   = PHASE_W;

    typedef enum logic [1:0] {
        LAG_NONE = 2'd0,
        LAG_CH0  = 2'd1,
        LAG_CH1  = 2'd2
    } lag_side_e;

    typedef struct packed {
        lag_side_e        side;
        logic [MAG_W-1:0] mag;
    } phase_cfg_t;

    // Turn the raw signed phase word into a lagging side and a clamped magnitude.
    function automatic phase_cfg_t decode_phase(input logic [PHASE_W-1:0] raw,
                                                input int unsigned max_mag);
        logic [PHASE_W:0] ext;
        logic [PHASE_W:0] absval;
        phase_cfg_t       c;
        ext    = {raw[PHASE_W-1], raw};
        absval = raw[PHASE_W-1] ? ((~ext) + {{PHASE_W{1'b0}}, 1'b1}) : ext;
        if ({{(31-PHASE_W){1'b0}}, absval} > max_mag)
            absval = max_mag[PHASE_W:0];
        c.mag  = absval[MAG_W-1:0];
        if (absval == '0)
            c.side = LAG_NONE;
        else if (raw[PHASE_W-1])
            c.side = LAG_CH1;
        else
            c.side = LAG_CH0;
        return c;
    endfunction

endpackage

// File: rtl/pda_phase_ctrl.sv
module pda_phase_ctrl
    import pda_pkg::*;
#(
    parameter int OSR = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [PHASE_W-1:0] wr_data,
    output phase_cfg_t         cfg_now,
    output logic               flush,
    output logic               resync
);
    localparam int unsigned MAX_DLY = OSR - 1;

    phase_cfg_t cfg_q;
    phase_cfg_t cfg_dec;

    always_comb begin
        cfg_dec = decode_phase(wr_data, MAX_DLY);
        cfg_now = wr_en ? cfg_dec : cfg_q;
        flush   = wr_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '{side: LAG_NONE, mag: '0};
            resync <= 1'b0;
        end else begin
            if (wr_en)
                cfg_q <= cfg_dec;
            resync <= wr_en;
        end
    end

    // R4: the stored magnitude never exceeds the clamp limit
    assert_mag_clamped_R4: assert property (@(posedge clk) disable iff (rst)
        int'(cfg_q.mag) <= OSR - 1);

    // R3: a zero magnitude and "no lagging side" always go together
    assert_side_matches_mag_R3: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.side == LAG_NONE) == (cfg_q.mag == '0));

endmodule

// File: rtl/pda_delay_line.sv
module pda_delay_line #(
    parameter int CODE_W  = 4,
    parameter int MAX_DLY = 63,
    parameter int SEL_W   = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              adv,
    input  logic [CODE_W-1:0] din,
    input  logic [SEL_W-1:0]  dly,
    output logic [CODE_W-1:0] dout
);
    logic [CODE_W-1:0] hist [MAX_DLY];
    logic [CODE_W-1:0] picked;

    generate
        for (genvar k = 0; k < MAX_DLY; k++) begin : g_stage
            logic [CODE_W-1:0] src;
            if (k == 0) begin : g_head
                assign src = din;
            end else begin : g_body
                assign src = hist[k-1];
            end
            always_ff @(posedge clk) begin
                if (rst)
                    hist[k] <= '0;
                else if (flush)
                    hist[k] <= (k == 0 && adv) ? din : '0;
                else if (adv)
                    hist[k] <= src;
            end
        end
    endgenerate

    // Tap 0 is the live input; deeper taps read history, which a flush empties.
    always_comb begin
        picked = din;
        if (dly != '0)
            picked = flush ? '0 : hist[dly - SEL_W'(1)];
    end

    always_ff @(posedge clk) begin
        if (rst)
            dout <= '0;
        else if (adv)
            dout <= picked;
    end

    // R2: with no delay the sample of one cycle earlier appears unchanged
    assert_tap0_passthru_R2: assert property (@(posedge clk) disable iff (rst)
        (adv && dly == '0) |=> (dout == $past(din)));

    // R5: a flushed delayed lane emits the zero code for the write-cycle sample
    assert_flush_zero_fill_R5: assert property (@(posedge clk) disable iff (rst)
        (adv && flush && dly != '0) |=> (dout == '0));

    // R6: the output holds when no sample arrives
    assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(dout));

endmodule

// File: rtl/pda_frame_cnt.sv
module pda_frame_cnt #(
    parameter int OSR = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic flush,
    input  logic adv,
    output logic valid_o,
    output logic frame_o
);
    localparam int CNT_W = (OSR > 1) ? $clog2(OSR) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] idx;
    logic             last;

    always_comb begin
        idx  = flush ? '0 : cnt;
        last = (idx == LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            valid_o <= 1'b0;
            frame_o <= 1'b0;
        end else begin
            if (adv)
                cnt <= last ? '0 : idx + CNT_W'(1);
            else if (flush)
                cnt <= '0;
            valid_o <= adv;
            frame_o <= adv && last;
        end
    end

    // R7: the frame strobe only ever marks a real output sample
    assert_frame_on_valid_R7: assert property (@(posedge clk) disable iff (rst)
        frame_o |-> valid_o);

    // R6: an output sample needs an input sample one cycle before
    assert_valid_latency_R6: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> $past(adv));

endmodule

// File: rtl/pda_phase_aligner.sv
module pda_phase_aligner
    import pda_pkg::*;
#(
    parameter int CODE_W = 4,
    parameter int OSR    = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [CODE_W-1:0]  in_code0,
    input  logic [CODE_W-1:0]  in_code1,
    input  logic               phase_wr,
    input  logic [PHASE_W-1:0] phase_wdata,
    output logic               out_valid,
    output logic [CODE_W-1:0]  out_code0,
    output logic [CODE_W-1:0]  out_code1,
    output logic               out_frame,
    output logic               out_resync
);
    localparam int MAX_DLY = OSR - 1;
    localparam int SEL_W   = $clog2(OSR);
    localparam int LANES   = 2;

    phase_cfg_t        cfg_now;
    logic              flush;
    logic [CODE_W-1:0] lane_in  [LANES];
    logic [CODE_W-1:0] lane_out [LANES];
    logic [SEL_W-1:0]  lane_dly [LANES];

    assign lane_in[0] = in_code0;
    assign lane_in[1] = in_code1;
    assign out_code0  = lane_out[0];
    assign out_code1  = lane_out[1];

    pda_phase_ctrl #(.OSR(OSR)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (phase_wr),
        .wr_data (phase_wdata),
        .cfg_now (cfg_now),
        .flush   (flush),
        .resync  (out_resync)
    );

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            localparam lag_side_e MY_SIDE = (g == 0) ? LAG_CH0 : LAG_CH1;
            assign lane_dly[g] = (cfg_now.side == MY_SIDE) ? cfg_now.mag[SEL_W-1:0] : '0;

            pda_delay_line #(
                .CODE_W  (CODE_W),
                .MAX_DLY (MAX_DLY),
                .SEL_W   (SEL_W)
            ) u_line (
                .clk   (clk),
                .rst   (rst),
                .flush (flush),
                .adv   (in_valid),
                .din   (lane_in[g]),
                .dly   (lane_dly[g]),
                .dout  (lane_out[g])
            );
        end
    endgenerate

    pda_frame_cnt #(.OSR(OSR)) u_frame (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush),
        .adv     (in_valid),
        .valid_o (out_valid),
        .frame_o (out_frame)
    );

    // R3: at most one lane is ever delayed
    assert_single_lag_R3: assert property (@(posedge clk) disable iff (rst)
        (lane_dly[0] == '0) || (lane_dly[1] == '0));

    // R8: a sample taken in a write cycle leaves a delayed lane at the zero code
    assert_write_sample_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (out_resync && out_valid && $past(lane_dly[0]) != '0) |-> (out_code0 == '0));

    assert_write_sample_zero1_R8: assert property (@(posedge clk) disable iff (rst)
        (out_resync && out_valid && $past(lane_dly[1]) != '0) |-> (out_code1 == '0));

endmodule

// File: tb/pda_phase_aligner_tb.sv
module pda_phase_aligner_tb;
    localparam int CODE_W = 4;
    localparam int OSR    = 64;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [CODE_W-1:0] in_code0 = '0;
    logic [CODE_W-1:0] in_code1 = '0;
    logic              phase_wr = 1'b0;
    logic [7:0]        phase_wdata = '0;
    logic              out_valid;
    logic [CODE_W-1:0] out_code0;
    logic [CODE_W-1:0] out_code1;
    logic              out_frame;
    logic              out_resync;

    pda_phase_aligner #(.CODE_W(CODE_W), .OSR(OSR)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_code0(in_code0),
        .in_code1(in_code1), .phase_wr(phase_wr), .phase_wdata(phase_wdata),
        .out_valid(out_valid), .out_code0(out_code0), .out_code1(out_code1),
        .out_frame(out_frame), .out_resync(out_resync)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural model state
    int d0 = 0, d1 = 0, n = 0;
    int h0[$];
    int h1[$];
    int e_valid = 0, e_frame = 0, e_resync = 0, e_code0 = 0, e_code1 = 0;
    string cur_tag = "R1";

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        d0 = 0; d1 = 0; n = 0;
        h0.delete(); h1.delete();
        e_valid = 0; e_frame = 0; e_resync = 0; e_code0 = 0; e_code1 = 0;
    endtask

    task automatic model_phase(input logic [7:0] wd);
        int p, m;
        p = int'(signed'(wd));
        m = (p < 0) ? -p : p;
        if (m > OSR - 1) m = OSR - 1;
        d0 = (p > 0) ? m : 0;
        d1 = (p < 0) ? m : 0;
        h0.delete(); h1.delete();
        n = 0;
    endtask

    // Drive one cycle at the falling edge, predict, then compare at the next falling edge.
    task automatic step(input bit v, input bit wr, input logic [7:0] wd,
                        input logic [CODE_W-1:0] a, input logic [CODE_W-1:0] b);
        in_valid = v; phase_wr = wr; phase_wdata = wd; in_code0 = a; in_code1 = b;
        if (wr) model_phase(wd);
        e_resync = wr;
        e_valid  = v;
        e_frame  = 0;
        if (v) begin
            h0.push_back(int'(a));
            h1.push_back(int'(b));
            e_code0 = (n >= d0) ? h0[n - d0] : 0;
            e_code1 = (n >= d1) ? h1[n - d1] : 0;
            e_frame = ((n % OSR) == OSR - 1) ? 1 : 0;
            n++;
        end
        @(negedge clk);
        chk("R6", "out_valid", int'(out_valid), e_valid);
        chk("R5", "out_resync", int'(out_resync), e_resync);
        chk("R7", "out_frame", int'(out_frame), e_frame);
        chk(cur_tag, "out_code0", int'(out_code0), e_code0);
        chk(cur_tag, "out_code1", int'(out_code1), e_code1);
    endtask

    // Identical streams on both channels, random gaps in the strobe.
    task automatic run(input int cycles, input int idle_pct);
        for (int i = 0; i < cycles; i++) begin
            logic [CODE_W-1:0] c;
            c = CODE_W'($urandom);
            step(($urandom % 100) >= idle_pct, 1'b0, 8'h00, c, c);
        end
    endtask

    task automatic write_phase(input logic [7:0] wd, input bit with_sample);
        logic [CODE_W-1:0] c;
        c = CODE_W'($urandom);
        step(with_sample, 1'b1, wd, c, c);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state at the ports
        chk("R1", "out_code0", int'(out_code0), 0);
        chk("R1", "out_code1", int'(out_code1), 0);
        chk("R1", "out_valid", int'(out_valid), 0);
        chk("R1", "out_frame", int'(out_frame), 0);
        chk("R1", "out_resync", int'(out_resync), 0);
        cur_tag = "R1";
        run(20, 0);                 // zero delay straight after reset

        cur_tag = "R6";
        run(150, 30);               // gaps, both lanes undelayed, frames counted

        cur_tag = "R2";
        write_phase(8'd5, 1'b0);
        run(300, 25);

        cur_tag = "R3";
        write_phase(8'hF9, 1'b0);   // -7
        run(300, 25);
        write_phase(8'h00, 1'b0);   // zero: no lane delayed
        run(80, 10);

        cur_tag = "R4";
        write_phase(8'd127, 1'b0);
        run(200, 10);
        write_phase(8'h80, 1'b0);   // -128
        run(200, 10);

        cur_tag = "R8";
        write_phase(8'd3, 1'b1);    // write coincides with a sample
        run(150, 20);
        write_phase(8'hFE, 1'b1);   // -2, again colliding
        run(150, 0);

        cur_tag = "R5";
        write_phase(8'd10, 1'b0);   // flush mid-stream, then zero fill
        run(100, 40);
        write_phase(8'hF0, 1'b1);   // -16
        run(140, 0);

        cur_tag = "R7";
        write_phase(8'd1, 1'b0);
        run(3 * OSR + 5, 0);        // back-to-back frames

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule